// File: doc/BRIEF.md
# Ethernet audio packet filter

This block lives in the receive clock domain of a raw-Ethernet link. A MAC receive unit hands it one 32-bit word per cycle whenever a valid strobe is high, and ends each frame with a single-cycle pulse that reports either a good or a bad CRC. The filter compares the first four words of every frame against a fixed broadcast audio header. For frames that match, it forwards the PCM sample words that follow.

Forwarded samples leave on a 32-bit data bus with a one-cycle write strobe. The strobe is meant to drive the write side of a FIFO that crosses into the audio clock domain. Frames that fail any header comparison produce no writes: their remaining words are dropped until the end pulse arrives. Control is a saturating word counter plus a sticky pass flag. There is no parser state machine.

Top module: `eaf_top`

## Requirements
- R1: While the synchronous reset `rst` is high, `out_we` is 0. After reset, the next valid word is treated as header word 0 of a new packet.
- R2: Header word 0 (index 0) must equal 0xFFFFFFFF, or the packet is rejected.
- R3: Header word 1 must carry 0xFFFF in bits 31:16 and 0x0090 in bits 15:0, or the packet is rejected.
- R4: Header word 2 must equal 0xC2001C50, or the packet is rejected.
- R5: Header word 3 must carry 0x0101 in bits 31:16. Bits 15:0 of that word are ignored, and any value there still passes.
- R6: In a passing packet, every valid word with index 4 to 1027 is written out in the same cycle it arrives, with `out_we` = 1 and `out_data` equal to `in_data`, in arrival order.
- R7: Header words (index 0 to 3) are never written out.
- R8: Once a header word mismatches, no word of that packet is written out, up to its end pulse.
- R9: A pulse on `pkt_end_good` or on `pkt_end_bad` ends the current packet. The next valid word is header word 0 of a new packet, and the pass status is restored.
- R10: The word index advances only on cycles where `in_vld` is 1. Cycles with `in_vld` = 0 never write and do not shift the index.
- R11: Valid words beyond index 1027 are dropped, however long the packet runs. The index saturates and never wraps back into the header range.
- R12: A valid word that arrives in the same cycle as an end pulse belongs to the ending packet and is handled by that packet's rules. The state is reset after that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Ethernet receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Received frame word |
| in_vld | input | 1 | `in_data` holds a word this cycle |
| pkt_end_good | input | 1 | One-cycle end of packet, CRC good |
| pkt_end_bad | input | 1 | One-cycle end of packet, CRC bad |
| out_data | output | 32 | Sample word toward the downstream buffer |
| out_we | output | 1 | Write strobe for `out_data` |

## Verification
The output strobe is a combinational function of the word counter and the pass flag, so a wrong counter value appears at the ports in the very cycle it matters. An index that is off by one shifts the first write to the fourth or the sixth word, or lets the 1029th word through. A pass flag that is not sticky, or that is not restored at an end pulse, shows up on the first sample word of the affected packet, at most four valid words after the fault. Comparing against a behavioural model on every cycle catches both kinds of fault at the first divergent word.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

    localparam int DATA_W    = 32;
    localparam int HDR_WORDS = 4;

    // Expected header word contents; compared under hdr_mask.
    function automatic logic [DATA_W-1:0] hdr_expect(input int idx);
        case (idx)
            0:       return 32'hFFFF_FFFF;
            1:       return 32'hFFFF_0090;
            2:       return 32'hC200_1C50;
            default: return 32'h0101_0000;
        endcase
    endfunction

    // Last header word carries 16 bits of padding that are not compared.
    function automatic logic [DATA_W-1:0] hdr_mask(input int idx);
        return (idx == HDR_WORDS - 1) ? 32'hFFFF_0000 : 32'hFFFF_FFFF;
    endfunction

endpackage

// File: rtl/eaf_hdr_match.sv
module eaf_hdr_match
    import eaf_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0]  idx,
    input  logic [DATA_W-1:0] data,
    output logic              word_ok
);

    logic [HDR_WORDS-1:0] sel;
    logic [HDR_WORDS-1:0] hit;

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
        localparam logic [CNT_W-1:0]  IDX_C = CNT_W'(g);
        localparam logic [DATA_W-1:0] EXP_C = hdr_expect(g);
        localparam logic [DATA_W-1:0] MSK_C = hdr_mask(g);
        assign sel[g] = (idx == IDX_C);
        assign hit[g] = ((data & MSK_C) == EXP_C);
    end

    // Words outside the header never fail the comparison.
    assign word_ok = (sel == '0) || ((sel & hit) != '0);

endmodule

// File: rtl/eaf_window.sv
module eaf_window #(
    parameter int CNT_W = 11,
    parameter int FIRST = 4,
    parameter int LAST  = 1027
) (
    input  logic [CNT_W-1:0] idx,
    output logic             in_win
);

    localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(FIRST);
    localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(LAST);

    assign in_win = (idx >= FIRST_C) && (idx <= LAST_C);

endmodule

// File: rtl/eaf_top.sv
module eaf_top
    import eaf_pkg::*;
#(
    parameter int SAMPLE_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       in_data,
    input  logic              in_vld,
    input  logic              pkt_end_good,
    input  logic              pkt_end_bad,
    output logic [31:0]       out_data,
    output logic              out_we
);

    localparam int TOTAL = HDR_WORDS + SAMPLE_WORDS;
    localparam int CNT_W = $clog2(TOTAL + 1);
    localparam logic [CNT_W-1:0] SAT_C = CNT_W'(TOTAL);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pass;
    } state_t;

    localparam state_t INIT_C = '{cnt: '0, pass: 1'b1};

    state_t st_q, st_d;
    logic   word_ok;
    logic   in_win;
    logic   pkt_end;

    eaf_hdr_match #(.CNT_W(CNT_W)) u_match (
        .idx     (st_q.cnt),
        .data    (in_data),
        .word_ok (word_ok)
    );

    eaf_window #(.CNT_W(CNT_W), .FIRST(HDR_WORDS), .LAST(TOTAL - 1)) u_win (
        .idx    (st_q.cnt),
        .in_win (in_win)
    );

    assign pkt_end = pkt_end_good | pkt_end_bad;

    always_comb begin
        st_d = st_q;
        if (in_vld) begin
            if (!word_ok) st_d.pass = 1'b0;
            if (st_q.cnt != SAT_C) st_d.cnt = st_q.cnt + 1'b1;
        end
        if (pkt_end) st_d = INIT_C;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= INIT_C;
        else     st_q <= st_d;
    end

    assign out_data = in_data;
    assign out_we   = !rst && in_vld && st_q.pass && in_win;

endmodule

// File: rtl/eaf_checker.sv
module eaf_checker #(
    parameter int HDR   = 4,
    parameter int TOTAL = 1028
) (
    input logic clk,
    input logic rst,
    input logic in_vld,
    input logic pkt_end_good,
    input logic pkt_end_bad,
    input logic out_we
);

    int unsigned ck_idx;

    always_ff @(posedge clk) begin
        if (rst || pkt_end_good || pkt_end_bad) ck_idx <= 0;
        else if (in_vld && ck_idx <= TOTAL) ck_idx <= ck_idx + 1;
    end

    always @(negedge clk) begin
        if (rst) assert_reset_quiet_R1: assert (!out_we);
    end

    assert_hdr_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        (ck_idx < HDR) |-> !out_we);

    assert_overlong_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (ck_idx >= TOTAL) |-> !out_we);

    assert_end_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (pkt_end_good || pkt_end_bad) |=> !out_we);

    assert_idle_no_write_R10: assert property (@(posedge clk) disable iff (rst)
        !in_vld |-> !out_we);

endmodule

bind eaf_top eaf_checker #(.HDR(eaf_pkg::HDR_WORDS), .TOTAL(eaf_pkg::HDR_WORDS + SAMPLE_WORDS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_vld       (in_vld),
    .pkt_end_good (pkt_end_good),
    .pkt_end_bad  (pkt_end_bad),
    .out_we       (out_we)
);

// File: tb/eaf_top_tb_top.sv
module eaf_top_tb_top;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] in_data = '0;
    logic        in_vld = 1'b0;
    logic        pkt_end_good = 1'b0;
    logic        pkt_end_bad = 1'b0;
    logic [31:0] out_data;
    logic        out_we;

    int n_vec  = 0;
    int n_fail = 0;
    int m_idx  = 0;
    bit m_pass = 1'b1;
    bit done   = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    eaf_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_data      (in_data),
        .in_vld       (in_vld),
        .pkt_end_good (pkt_end_good),
        .pkt_end_bad  (pkt_end_bad),
        .out_data     (out_data),
        .out_we       (out_we)
    );

    function automatic bit hdr_good(input int i, input logic [31:0] d);
        if (i == 0) return d == 32'hFFFFFFFF;
        if (i == 1) return d[31:16] == 16'hFFFF && d[15:0] == 16'h0090;
        if (i == 2) return d == 32'hC2001C50;
        if (i == 3) return d[31:16] == 16'h0101;
        return 1'b1;
    endfunction

    task automatic step(input bit r, input bit v, input logic [31:0] d,
                        input bit eg, input bit eb, input string tag);
        bit exp_we;
        @(negedge clk);
        rst = r; in_vld = v; in_data = d; pkt_end_good = eg; pkt_end_bad = eb;
        #1;
        exp_we = !r && v && m_pass && m_idx >= 4 && m_idx <= 1027;
        n_vec++;
        if (out_we !== exp_we || (exp_we && out_data !== d)) begin
            n_fail++;
            $display("FAIL %s idx=%0d we=%0b exp=%0b data=%h exp=%h",
                     tag, m_idx, out_we, exp_we, out_data, d);
        end
        if (r || eg || eb) begin
            m_idx = 0; m_pass = 1'b1;
        end else if (v) begin
            if (!hdr_good(m_idx, d)) m_pass = 1'b0;
            m_idx++;
        end
    endtask

    // Send a frame; word bad_at (if >=0) is replaced with bad_val.
    task automatic send_pkt(input int nw, input int bad_at, input logic [31:0] bad_val,
                            input int gap, input bit end_bad, input string tag);
        logic [31:0] w;
        for (int i = 0; i < nw; i++) begin
            case (i)
                0: w = 32'hFFFFFFFF;
                1: w = 32'hFFFF0090;
                2: w = 32'hC2001C50;
                3: w = {16'h0101, 16'(i * 7 + nw)};
                default: w = 32'hA5000000 ^ (i * 32'h9E37) ^ nw;
            endcase
            if (i == bad_at) w = bad_val;
            if (gap != 0 && i % gap == 1) step(1'b0, 1'b0, 32'hDEADBEEF, 1'b0, 1'b0, tag);
            step(1'b0, 1'b1, w, 1'b0, 1'b0, tag);
        end
        step(1'b0, 1'b0, '0, !end_bad, end_bad, tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, "R1 reset");
        send_pkt(1028, -1, '0, 0, 1'b0, "R6 R7 clean packet");
        send_pkt(1028, -1, '0, 5, 1'b1, "R10 R9 gaps, bad-CRC end");
        send_pkt(1028, 0, 32'hFFFFFFFE, 0, 1'b0, "R2 R8 word0 mismatch");
        send_pkt(1028, 1, 32'hFFFF0091, 0, 1'b0, "R3 R8 word1 low mismatch");
        send_pkt(40, 1, 32'hFFFE0090, 0, 1'b0, "R3 word1 high mismatch");
        send_pkt(1028, 2, 32'hC2001C51, 0, 1'b1, "R4 R8 word2 mismatch");
        send_pkt(1028, 3, 32'h0102ABCD, 0, 1'b0, "R5 word3 type mismatch");
        send_pkt(60, 3, 32'h0101FFFF, 0, 1'b0, "R5 padding ignored");
        send_pkt(2, -1, '0, 0, 1'b1, "R9 short packet");
        send_pkt(1100, -1, '0, 0, 1'b0, "R11 overlong packet");
        // Word arriving together with the end pulse (R12).
        send_pkt(0, -1, '0, 0, 1'b0, "R9 empty end");
        for (int i = 0; i < 10; i++)
            step(1'b0, 1'b1, (i < 4) ? (i == 3 ? 32'h01010000 : (i == 1 ? 32'hFFFF0090 : (i == 2 ? 32'hC2001C50 : 32'hFFFFFFFF))) : 32'h1000 + i,
                 1'b0, 1'b0, "R12 prefix");
        step(1'b0, 1'b1, 32'h77777777, 1'b1, 1'b0, "R12 word with end pulse");
        step(1'b0, 1'b1, 32'hFFFFFFFF, 1'b0, 1'b0, "R12 R9 restart word0");
        // Reset in the middle of a packet (R1).
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 32'h12345678, 1'b0, 1'b0, "R1 junk");
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 mid reset");
        send_pkt(200, -1, '0, 3, 1'b0, "R1 R6 after reset");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule